// File: doc/BRIEF.md
# Parallel NOR Flash Identification Controller

This block finds out which part sits on an 8-bit asynchronous NOR flash bus. A single-cycle start pulse begins a probe. The controller first reads location 0 over and over until the device returns the same byte twice in a row, so that any program or erase still in flight has finished. It then sends a reset command and the three-write unlock and autoselect sequence. It reads the manufacturer code and the device code, and checks each of them for odd parity. It then looks up the pair in a table of known parts, computed in logic.

Every probe ends with a reset command that puts the device back into array-read mode, whatever the result. A one-cycle done pulse then reports whether the part was recognised, the 16-bit identifier, the device size in KiB and the sector size in KiB. These results stay unchanged until the next start. Bus writes hold address and data for a parameter number of clocks, with the write strobe raised only in the middle of that window. Bus reads keep the read strobe high for a parameter access delay before the data is sampled.

Top module: `flash_id_probe`

## Requirements
- R1: Before any write, the controller reads offset 0 until two consecutive reads return equal bytes. It stops after SETTLE_MAX comparison reads (SETTLE_MAX+1 reads in all) and continues with the probe either way.
- R2: After settling, the first four bus writes are, in order, (0x555, 0xF0), (0x555, 0xAA), (0x2AA, 0x55) and (0x555, 0x90), given as (address, data).
- R3: After the fourth write, the controller reads offset 0 for the manufacturer code and then offset 1 for the device code. part_id_o is {manufacturer, device}.
- R4: If either code has even parity (an even count of ones), found_o is 0.
- R5: When both codes have odd parity, found_o is 1 for keys 0x013D, 0x01AD and 0xC2AD with size 2048 KiB, for 0x01D5 with size 1024 KiB, and for 0x01A4 and 0x20E3 with size 512 KiB. In every found case sect_kib_o is 64.
- R6: For any key that is not found, size_kib_o and sect_kib_o are 0.
- R7: The fifth and last write of every probe is (0x555, 0xF0), and it completes before done_o rises.
- R8: Each write keeps fl_addr_o and fl_wdata_o stable for WR_CYCLES clocks, with fl_wr_o high for exactly WR_CYCLES-2 clocks inside that window. fl_wr_o and fl_rd_o are never high together.
- R9: Read data is sampled only after fl_rd_o has been high for RD_DELAY+1 clocks.
- R10: done_o is a one-cycle pulse. The result outputs stay unchanged from the pulse until the next accepted start. A start that arrives during a probe is ignored.
- R11: After reset, done_o, found_o, fl_wr_o and fl_rd_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a probe when idle |
| done_o | output | 1 | One-cycle pulse at the end of a probe |
| found_o | output | 1 | Part recognised |
| part_id_o | output | 16 | {manufacturer, device} code read back |
| size_kib_o | output | 12 | Device size in KiB, 0 when not found |
| sect_kib_o | output | 8 | Sector size in KiB, 0 when not found |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_rdata_i | input | 8 | Flash read data |
| fl_wr_o | output | 1 | Write strobe, active high |
| fl_rd_o | output | 1 | Read strobe, active high |

## Verification
The assertions assume that start_i is a clean synchronous level and that the flash drives valid data by the end of the read access window. They make no assumption about what codes the device returns. The bench's flash model therefore returns an inverted byte until the read strobe has been high long enough. It changes the location-0 byte from one read to the next for a random number of reads, so that both the early match and the give-up limit of the settle loop are reached. Identifier pairs come half from the known table and half as random bytes. Start pulses arrive only at the falling clock edge, and one directed probe sends a second start while a probe is running.

// File: rtl/fidp_pkg.sv
package fidp_pkg;
   localparam logic [7:0]  CMD_RESET    = 8'hF0;
   localparam logic [7:0]  CMD_UNLOCK_A = 8'hAA;
   localparam logic [7:0]  CMD_UNLOCK_B = 8'h55;
   localparam logic [7:0]  CMD_AUTOSEL  = 8'h90;
   localparam logic [15:0] OFS_CMD_A    = 16'h0555;
   localparam logic [15:0] OFS_CMD_B    = 16'h02AA;

   typedef enum logic [3:0] {
      ST_IDLE, ST_SETTLE, ST_RST0, ST_UNL1, ST_UNL2, ST_ASEL,
      ST_RD_MFR, ST_RD_DEV, ST_RSTF
   } probe_state_t;

   typedef struct packed {
      logic        hit;
      logic [11:0] size_kib;
      logic [7:0]  sect_kib;
   } part_info_t;

   function automatic part_info_t part_decode(input logic [15:0] key);
      part_info_t r;
      r = '0;
      unique case (key)
         16'h013D, 16'h01AD, 16'hC2AD: r = '{1'b1, 12'd2048, 8'd64};
         16'h01D5:                     r = '{1'b1, 12'd1024, 8'd64};
         16'h01A4, 16'h20E3:           r = '{1'b1, 12'd512,  8'd64};
         default:                      r = '0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/fidp_bus_engine.sv
module fidp_bus_engine #(
   parameter int ADDR_W    = 12,
   parameter int WR_CYCLES = 4,
   parameter int RD_DELAY  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              is_wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] fl_addr_o,
   output logic [7:0]        fl_wdata_o,
   output logic              fl_wr_o,
   output logic              fl_rd_o
);
   localparam int LAST_MAX = (WR_CYCLES - 1 > RD_DELAY) ? WR_CYCLES - 1 : RD_DELAY;
   localparam int CW       = $clog2(LAST_MAX + 1) + 1;
   localparam logic [CW-1:0] WR_LAST = CW'(WR_CYCLES - 1);
   localparam logic [CW-1:0] RD_LAST = CW'(RD_DELAY);

   generate
      if (WR_CYCLES < 3) begin : g_bad_wr
         $error("WR_CYCLES must be at least 3");
      end
      if (RD_DELAY < 1) begin : g_bad_rd
         $error("RD_DELAY must be at least 1");
      end
   endgenerate

   logic              act_q, wr_q;
   logic [CW-1:0]     cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;

   assign done_o = act_q && (cnt_q == (wr_q ? WR_LAST : RD_LAST));
   assign busy_o = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         wr_q   <= 1'b0;
         cnt_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else if (!act_q) begin
         if (req_i) begin
            act_q  <= 1'b1;
            wr_q   <= is_wr_i;
            cnt_q  <= '0;
            addr_q <= addr_i;
            data_q <= is_wr_i ? wdata_i : 8'h00;
         end
      end else if (done_o) begin
         act_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign fl_addr_o  = addr_q;
   assign fl_wdata_o = data_q;
   assign fl_wr_o    = act_q && wr_q && (cnt_q != '0) && (cnt_q != WR_LAST);
   assign fl_rd_o    = act_q && !wr_q;

   AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_wr_o && fl_rd_o)); // R8
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && wr_q && cnt_q != '0) |-> ($stable(fl_addr_o) && $stable(fl_wdata_o))); // R8
endmodule

// File: rtl/fidp_part_check.sv
module fidp_part_check
   import fidp_pkg::*;
(
   input  logic [7:0] mfr_i,
   input  logic [7:0] dev_i,
   output part_info_t info_o
);
   logic       par_ok;
   part_info_t tbl;

   assign par_ok = (^mfr_i) && (^dev_i);
   assign tbl    = part_decode({mfr_i, dev_i});

   always_comb begin
      info_o = '0;
      if (par_ok && tbl.hit) info_o = tbl;
   end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
   import fidp_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int WR_CYCLES  = 4,
   parameter int RD_DELAY   = 2,
   parameter int SETTLE_MAX = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              done_o,
   output logic              found_o,
   output logic [15:0]       part_id_o,
   output logic [11:0]       size_kib_o,
   output logic [7:0]        sect_kib_o,
   output logic [ADDR_W-1:0] fl_addr_o,
   output logic [7:0]        fl_wdata_o,
   input  logic [7:0]        fl_rdata_i,
   output logic              fl_wr_o,
   output logic              fl_rd_o
);
   localparam int TW = $clog2(SETTLE_MAX + 1);
   localparam logic [TW-1:0] TRY_LAST = TW'(SETTLE_MAX - 1);

   generate
      if (ADDR_W < 11) begin : g_bad_aw
         $error("ADDR_W must reach offset 0x555");
      end
      if (SETTLE_MAX < 1) begin : g_bad_settle
         $error("SETTLE_MAX must be at least 1");
      end
   endgenerate

   probe_state_t      st_q;
   logic              first_q;
   logic [7:0]        prev_q, mfr_q, dev_q;
   logic [TW-1:0]     try_q;
   logic              req, is_wr, eng_busy, eng_done;
   logic [ADDR_W-1:0] req_addr;
   logic [7:0]        req_data;
   part_info_t        info;

   always_comb begin
      is_wr    = 1'b1;
      req_addr = ADDR_W'(OFS_CMD_A);
      req_data = CMD_RESET;
      unique case (st_q)
         ST_SETTLE: begin is_wr = 1'b0; req_addr = '0; end
         ST_UNL1:   req_data = CMD_UNLOCK_A;
         ST_UNL2:   begin req_addr = ADDR_W'(OFS_CMD_B); req_data = CMD_UNLOCK_B; end
         ST_ASEL:   req_data = CMD_AUTOSEL;
         ST_RD_MFR: begin is_wr = 1'b0; req_addr = '0; end
         ST_RD_DEV: begin is_wr = 1'b0; req_addr = ADDR_W'(1); end
         default:   ;
      endcase
   end
   assign req = (st_q != ST_IDLE) && !eng_busy;

   fidp_bus_engine #(
      .ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES), .RD_DELAY(RD_DELAY)
   ) u_bus (
      .clk(clk), .rst_n(rst_n), .req_i(req), .is_wr_i(is_wr),
      .addr_i(req_addr), .wdata_i(req_data), .busy_o(eng_busy), .done_o(eng_done),
      .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_wr_o(fl_wr_o), .fl_rd_o(fl_rd_o)
   );

   fidp_part_check u_check (.mfr_i(mfr_q), .dev_i(dev_q), .info_o(info));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         first_q <= 1'b1;
         prev_q <= '0;
         mfr_q <= '0;
         dev_q <= '0;
         try_q <= '0;
         done_o <= 1'b0;
         found_o <= 1'b0;
         part_id_o <= '0;
         size_kib_o <= '0;
         sect_kib_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q <= ST_SETTLE;
               first_q <= 1'b1;
               try_q <= '0;
               found_o <= 1'b0;
               part_id_o <= '0;
               size_kib_o <= '0;
               sect_kib_o <= '0;
            end
            ST_SETTLE: if (eng_done) begin
               prev_q <= fl_rdata_i;
               first_q <= 1'b0;
               if (!first_q) begin
                  if (fl_rdata_i == prev_q || try_q == TRY_LAST) st_q <= ST_RST0;
                  else try_q <= try_q + 1'b1;
               end
            end
            ST_RST0: if (eng_done) st_q <= ST_UNL1;
            ST_UNL1: if (eng_done) st_q <= ST_UNL2;
            ST_UNL2: if (eng_done) st_q <= ST_ASEL;
            ST_ASEL: if (eng_done) st_q <= ST_RD_MFR;
            ST_RD_MFR: if (eng_done) begin
               mfr_q <= fl_rdata_i;
               st_q <= ST_RD_DEV;
            end
            ST_RD_DEV: if (eng_done) begin
               dev_q <= fl_rdata_i;
               st_q <= ST_RSTF;
            end
            ST_RSTF: if (eng_done) begin
               st_q <= ST_IDLE;
               done_o <= 1'b1;
               found_o <= info.hit;
               part_id_o <= {mfr_q, dev_q};
               size_kib_o <= info.size_kib;
               sect_kib_o <= info.sect_kib;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R10
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !start_i) |=> ($stable(found_o) && $stable(part_id_o) && $stable(size_kib_o))); // R10
   AST_FOUND_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> ((^part_id_o[15:8]) && (^part_id_o[7:0]))); // R4
   AST_FOUND_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> (sect_kib_o == 8'd64 && size_kib_o != '0)); // R5
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !found_o |-> (size_kib_o == '0 && sect_kib_o == '0)); // R6
   AST_DONE_AFTER_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!fl_wr_o && !fl_rd_o)); // R7
endmodule

// File: tb/flash_id_probe_tb.sv
module flash_id_probe_tb;
   localparam int AW = 12, WRC = 4, RDD = 2, SMAX = 20;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic done_o, found_o, fl_wr_o, fl_rd_o;
   logic [15:0] part_id_o;
   logic [11:0] size_kib_o;
   logic [7:0]  sect_kib_o, fl_wdata_o, fl_rdata_i;
   logic [AW-1:0] fl_addr_o;

   always #5 clk = ~clk;

   flash_id_probe #(.ADDR_W(AW), .WR_CYCLES(WRC), .RD_DELAY(RDD), .SETTLE_MAX(SMAX)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done_o), .found_o(found_o),
      .part_id_o(part_id_o), .size_kib_o(size_kib_o), .sect_kib_o(sect_kib_o),
      .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_rdata_i(fl_rdata_i),
      .fl_wr_o(fl_wr_o), .fl_rd_o(fl_rd_o));

   int total = 0, bad = 0;
   // flash model state
   logic [7:0] m_mfr = 0, m_dev = 0;
   int m_t = 0, nset = 0, nwr = 0, nid = 0, hc = 0, wlen = 0, wr_bad = 0;
   logic autosel = 0, prev_wr = 0, prev_rd = 0;
   logic [AW-1:0] wa [8], ra [4], w_addr0;
   logic [7:0] wd [8], w_data0, mval;

   function automatic logic [7:0] settle_val(input int k, input int t);
      int m = (k < t) ? k : t;
      return 8'h3C ^ ((m % 2 == 1) ? 8'h40 : 8'h00);
   endfunction

   always_comb begin
      if (autosel) mval = (fl_addr_o == 0) ? m_mfr : (fl_addr_o == 1) ? m_dev : 8'h00;
      else mval = settle_val(nset, m_t);
   end
   assign fl_rdata_i = (hc >= RDD + 1) ? mval : ~mval;

   always @(negedge clk) begin
      if (fl_rd_o) hc <= hc + 1; else hc <= 0;
      if (prev_rd && !fl_rd_o) begin
         if (nwr == 0) nset <= nset + 1;
         else if (nid < 4) begin ra[nid] <= fl_addr_o; nid <= nid + 1; end
      end
      if (fl_wr_o && !prev_wr) begin w_addr0 <= fl_addr_o; w_data0 <= fl_wdata_o; wlen <= 1; end
      else if (fl_wr_o) begin
         wlen <= wlen + 1;
         if (fl_addr_o != w_addr0 || fl_wdata_o != w_data0) wr_bad <= wr_bad + 1;
      end
      if (prev_wr && !fl_wr_o) begin
         if (wlen != WRC - 2) wr_bad <= wr_bad + 1;
         if (nwr < 8) begin wa[nwr] <= w_addr0; wd[nwr] <= w_data0; end
         nwr <= nwr + 1;
         if (w_addr0 == 12'h555 && w_data0 == 8'h90) autosel <= 1'b1;
         if (w_data0 == 8'hF0) autosel <= 1'b0;
      end
      prev_wr <= fl_wr_o;
      prev_rd <= fl_rd_o;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] exp_size(input logic [7:0] m, input logic [7:0] d);
      if (!(^m) || !(^d)) return 12'd0;
      case ({m, d})
         16'h013D, 16'h01AD, 16'hC2AD: return 12'd2048;
         16'h01D5: return 12'd1024;
         16'h01A4, 16'h20E3: return 12'd512;
         default: return 12'd0;
      endcase
   endfunction

   logic [11:0] EXP_WA [5] = '{12'h555, 12'h555, 12'h2AA, 12'h555, 12'h555};
   logic [7:0]  EXP_WD [5] = '{8'hF0, 8'hAA, 8'h55, 8'h90, 8'hF0};

   task automatic run_probe(input logic [7:0] m, input logic [7:0] d, input int t, input bit poke);
      int cyc = 0;
      int exp_set;
      logic [11:0] es;
      logic [15:0] hid;
      logic hf;
      m_mfr = m; m_dev = d; m_t = t;
      nset = 0; nwr = 0; nid = 0; wr_bad = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (!done_o && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         start = (poke && cyc == 12);
      end
      start = 1'b0;
      chk(done_o, "R10 done seen", {31'd0, done_o}, 1);
      exp_set = (t + 1 <= SMAX) ? t + 2 : SMAX + 1;
      chk(nset == exp_set, "R1 settle reads", nset, exp_set);
      chk(nwr == 5, "R2 write count", nwr, 5);
      for (int i = 0; i < 5; i++) begin
         chk(wa[i] == EXP_WA[i] && wd[i] == EXP_WD[i], (i == 4) ? "R7 final reset" : "R2 command order",
             {wa[i], 12'd0, wd[i]}, {EXP_WA[i], 12'd0, EXP_WD[i]});
      end
      chk(wr_bad == 0, "R8 write window", wr_bad, 0);
      chk(nid == 2 && ra[0] == 0 && ra[1] == 1, "R3 id read offsets", {ra[0], 4'd0, ra[1]}, {12'd0, 4'd0, 12'd1});
      chk(part_id_o == {m, d}, "R3 R9 part id", part_id_o, {m, d});
      es = exp_size(m, d);
      chk(found_o == (es != 0), (^m && ^d) ? "R5 found" : "R4 parity reject", found_o, (es != 0));
      chk(size_kib_o == es, (es != 0) ? "R5 size" : "R6 size zero", size_kib_o, es);
      chk(sect_kib_o == ((es != 0) ? 8'd64 : 8'd0), (es != 0) ? "R5 sector" : "R6 sector zero",
          sect_kib_o, (es != 0) ? 64 : 0);
      hid = part_id_o; hf = found_o;
      repeat (4) @(negedge clk);
      chk(!done_o && part_id_o == hid && found_o == hf, "R10 hold", {hid, 15'd0, done_o}, {part_id_o, 16'd0});
   endtask

   initial begin
      int cyc_all = 0;
      forever begin
         @(negedge clk);
         cyc_all++;
         if (cyc_all > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc_all);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   logic [15:0] KEYS [6] = '{16'h013D, 16'h01AD, 16'h01D5, 16'h01A4, 16'h20E3, 16'hC2AD};

   initial begin
      void'($urandom(32'd7341));
      repeat (3) @(negedge clk);
      chk(!done_o && !found_o && !fl_wr_o && !fl_rd_o, "R11 reset state",
          {done_o, found_o, fl_wr_o, fl_rd_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!fl_wr_o && !fl_rd_o, "R11 idle bus", {fl_wr_o, fl_rd_o}, 0);
      // directed corners
      run_probe(8'h01, 8'hAD, 0, 0);        // R5 2 MiB, immediate settle
      run_probe(8'h01, 8'hD5, 5, 0);        // R5 1 MiB
      run_probe(8'h20, 8'hE3, SMAX - 1, 0); // R1 match on last allowed compare
      run_probe(8'hC2, 8'hAD, 40, 0);       // R1 give up
      run_probe(8'h03, 8'hAD, 1, 0);        // R4 even-parity manufacturer
      run_probe(8'h01, 8'hA5, 1, 0);        // R4 even-parity device
      run_probe(8'h01, 8'hB5, 2, 0);        // R6 odd parity, unknown key
      run_probe(8'h01, 8'hA4, 3, 1);        // R10 start during probe ignored
      for (int n = 0; n < 40; n++) begin
         logic [15:0] k;
         if ($urandom_range(1, 0) == 1) k = KEYS[$urandom_range(5, 0)];
         else k = 16'($urandom());
         run_probe(k[15:8], k[7:0], $urandom_range(SMAX + 5, 0), 0);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule